// File: doc/BRIEF.md
# Bridge Gate-Drive Controller

This block turns logic-level motor-control inputs into four registered gate commands, one for the high switch and one for the low switch of each of two legs, A and B. A mode input picks between driving one full H-bridge and driving two independent half-bridges. In full-bridge mode the control pins carry direction, chopping, quadrant select, enable and brake. In half-bridge mode three of them become a per-leg level input and a per-leg enable.

Every input, including the undervoltage flag and the two per-leg protection inhibits, passes through a two-flop synchroniser before it is decoded. A per-leg dead-time stage then holds off any gate turn-on until the request for that leg has been steady for `DEAD_CYC` clock cycles. Turn-offs are not delayed. The quadrant-select flop resets to 1, which selects chopping of the low switch only. The pins are plain levels with no handshake.

Top module: `bridge_gate_ctrl`

## Requirements
- R1: Full-bridge mode is selected by `mode_i`=1. With `en_ena_i`=1, `qs_inb_i`=1 and `pwm_enb_i`=1, `dir_ina_i`=1 turns on `gate_top_a_o` and `gate_bot_b_o`, and `dir_ina_i`=0 turns on `gate_top_b_o` and `gate_bot_a_o`. The other two gates stay off.
- R2: In full-bridge mode with `qs_inb_i`=1, `pwm_enb_i`=0 turns off the low switch of the active diagonal. The high switch of that diagonal stays on.
- R3: In full-bridge mode with `qs_inb_i`=0, both switches of the active diagonal follow `pwm_enb_i`. When `pwm_enb_i`=0, all four gates are off.
- R4: In full-bridge mode with `brk_i`=1 and the block enabled, both low gates are on and both high gates are off, whatever the values of direction, PWM and QS.
- R5: In full-bridge mode, `en_ena_i`=0 turns all four gates off, even while braking.
- R6: Half-bridge mode is selected by `mode_i`=0. Leg A takes its level from `dir_ina_i` and its enable from `en_ena_i`. Leg B takes its level from `qs_inb_i` and its enable from `pwm_enb_i`. An enabled leg with level 1 drives its high gate, and with level 0 drives its low gate. A disabled leg has both gates off. `brk_i` has no effect in this mode.
- R7: `uv_i`=1 turns all four gates off in either mode, overriding the brake.
- R8: A protection inhibit overrides every other command. In full-bridge mode, `inh_a_i` or `inh_b_i` turns off the whole bridge. In half-bridge mode, each inhibit turns off only its own leg.
- R9: The high and low gates of one leg are never on in the same cycle.
- R10: A change at the pins turns a gate off on the 3rd rising edge after the change and turns a gate on at edge `DEAD_CYC`+3. As a result, swapping a leg from one side to the other leaves both of its gates low for exactly `DEAD_CYC` cycles.
- R11: If a leg's request changes again while the leg is waiting out its dead time, the wait starts over from the latest change. The earlier request never reaches the gates.
- R12: All gates are low while `rst_n` is low and for at least `DEAD_CYC` cycles after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 1 = full H-bridge, 0 = two half-bridges |
| dir_ina_i | input | 1 | Direction (full) / leg A level (half) |
| pwm_enb_i | input | 1 | PWM (full) / leg B enable (half) |
| qs_inb_i | input | 1 | 1 = chop low switch only, 0 = chop both (full) / leg B level (half) |
| en_ena_i | input | 1 | Bridge enable (full) / leg A enable (half) |
| brk_i | input | 1 | Brake, full-bridge mode only |
| uv_i | input | 1 | Undervoltage flag |
| inh_a_i | input | 1 | Protection inhibit, leg A |
| inh_b_i | input | 1 | Protection inhibit, leg B |
| gate_top_a_o | output | 1 | High switch command, leg A |
| gate_bot_a_o | output | 1 | Low switch command, leg A |
| gate_top_b_o | output | 1 | High switch command, leg B |
| gate_bot_b_o | output | 1 | Low switch command, leg B |

## Verification
The hardest case to reach from the pins is a request that changes again while a leg is still inside its dead-time wait. Only the restart rule stops the first request from reaching the gate in that case. The stimulus reverses the direction input exactly four edges after a first reversal, so the leg is mid-count when the second change arrives. The bench then checks after every edge that no gate rises until `DEAD_CYC`+3 edges after the second change. A monitor watches for overlap of high and low gates on every cycle of the run.

// File: rtl/bgd_pkg.sv
package bgd_pkg;

  typedef enum logic [1:0] {
    LEG_OFF = 2'd0,
    LEG_TOP = 2'd1,
    LEG_BOT = 2'd2
  } leg_req_e;

  typedef struct packed {
    logic mode;
    logic dir_ina;
    logic pwm_enb;
    logic qs_inb;
    logic en_ena;
    logic brk;
    logic uv;
    logic inh_a;
    logic inh_b;
  } ctl_s;

  localparam int CTL_W = $bits(ctl_s);

  // quadrant select idles high: low-side-only chopping by default
  localparam ctl_s CTL_RST = '{mode: 1'b0, dir_ina: 1'b0, pwm_enb: 1'b0,
                               qs_inb: 1'b1, en_ena: 1'b0, brk: 1'b0,
                               uv: 1'b0, inh_a: 1'b0, inh_b: 1'b0};

  localparam int NUM_LEGS = 2;

endpackage

// File: rtl/bgd_sync.sv
module bgd_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/bgd_decode.sv
module bgd_decode
  import bgd_pkg::*;
(
  input  ctl_s     ctl,
  output leg_req_e req_a,
  output leg_req_e req_b
);

  leg_req_e diag_hi, diag_lo;

  // side requests of the active diagonal in full-bridge mode
  always_comb begin
    diag_hi = (ctl.qs_inb || ctl.pwm_enb) ? LEG_TOP : LEG_OFF;
    diag_lo = ctl.pwm_enb ? LEG_BOT : LEG_OFF;
  end

  always_comb begin
    req_a = LEG_OFF;
    req_b = LEG_OFF;
    if (ctl.mode) begin
      if (ctl.uv || ctl.inh_a || ctl.inh_b || !ctl.en_ena) begin
        req_a = LEG_OFF;
        req_b = LEG_OFF;
      end else if (ctl.brk) begin
        req_a = LEG_BOT;
        req_b = LEG_BOT;
      end else if (ctl.dir_ina) begin
        req_a = diag_hi;
        req_b = diag_lo;
      end else begin
        req_a = diag_lo;
        req_b = diag_hi;
      end
    end else if (!ctl.uv) begin
      if (!ctl.inh_a && ctl.en_ena) req_a = ctl.dir_ina ? LEG_TOP : LEG_BOT;
      if (!ctl.inh_b && ctl.pwm_enb) req_b = ctl.qs_inb ? LEG_TOP : LEG_BOT;
    end
  end

endmodule

// File: rtl/bgd_leg.sv
module bgd_leg
  import bgd_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  leg_req_e req,
  output logic     top_o,
  output logic     bot_o
);

  localparam int            CW   = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEAD_CYC - 1);

  leg_req_e      req_q;
  logic [CW-1:0] cnt;
  logic          settled;

  // request unchanged for DEAD_CYC cycles
  assign settled = (req == req_q) && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= LEG_OFF;
      cnt   <= '0;
      top_o <= 1'b0;
      bot_o <= 1'b0;
    end else begin
      req_q <= req;
      if (req != req_q)   cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + CW'(1);
      top_o <= (req == LEG_TOP) && settled;
      bot_o <= (req == LEG_BOT) && settled;
    end
  end

endmodule

// File: rtl/bridge_gate_ctrl.sv
module bridge_gate_ctrl
  import bgd_pkg::*;
#(
  parameter int DEAD_CYC    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic dir_ina_i,
  input  logic pwm_enb_i,
  input  logic qs_inb_i,
  input  logic en_ena_i,
  input  logic brk_i,
  input  logic uv_i,
  input  logic inh_a_i,
  input  logic inh_b_i,
  output logic gate_top_a_o,
  output logic gate_bot_a_o,
  output logic gate_top_b_o,
  output logic gate_bot_b_o
);

  ctl_s           ctl_raw, ctl_sync;
  logic [CTL_W-1:0] ctl_sync_bits;
  leg_req_e       req   [NUM_LEGS];
  logic           top_g [NUM_LEGS];
  logic           bot_g [NUM_LEGS];

  assign ctl_raw = '{mode: mode_i, dir_ina: dir_ina_i, pwm_enb: pwm_enb_i,
                     qs_inb: qs_inb_i, en_ena: en_ena_i, brk: brk_i,
                     uv: uv_i, inh_a: inh_a_i, inh_b: inh_b_i};

  bgd_sync #(
    .W       (CTL_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (CTL_RST)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ctl_raw),
    .q     (ctl_sync_bits)
  );

  assign ctl_sync = ctl_s'(ctl_sync_bits);

  bgd_decode u_dec (
    .ctl   (ctl_sync),
    .req_a (req[0]),
    .req_b (req[1])
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    bgd_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req[g]),
      .top_o (top_g[g]),
      .bot_o (bot_g[g])
    );
  end

  assign gate_top_a_o = top_g[0];
  assign gate_bot_a_o = bot_g[0];
  assign gate_top_b_o = top_g[1];
  assign gate_bot_b_o = bot_g[1];

endmodule

// File: rtl/bgd_chk.sv
module bgd_chk #(
  parameter int DEAD_CYC = 4
) (
  input logic clk,
  input logic rst_n,
  input logic mode_i,
  input logic en_ena_i,
  input logic uv_i,
  input logic inh_a_i,
  input logic inh_b_i,
  input logic gate_top_a_o,
  input logic gate_bot_a_o,
  input logic gate_top_b_o,
  input logic gate_bot_b_o
);

  localparam int            IW  = $clog2(DEAD_CYC + 1) + 1;
  localparam logic [IW-1:0] LIM = IW'(DEAD_CYC);

  logic [IW-1:0] idle_a, idle_b;
  logic          all_off;

  assign all_off = !gate_top_a_o && !gate_bot_a_o && !gate_top_b_o && !gate_bot_b_o;

  // cycles each leg has had both gates low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_a <= '0;
      idle_b <= '0;
    end else begin
      if (gate_top_a_o || gate_bot_a_o) idle_a <= '0;
      else if (idle_a != LIM)           idle_a <= idle_a + IW'(1);
      if (gate_top_b_o || gate_bot_b_o) idle_b <= '0;
      else if (idle_b != LIM)           idle_b <= idle_b + IW'(1);
    end
  end

  // R9
  no_shoot_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_top_a_o && gate_bot_a_o));

  // R9
  no_shoot_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_top_b_o && gate_bot_b_o));

  // R10
  dead_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_top_a_o) || $rose(gate_bot_a_o)) |-> (idle_a >= LIM));

  // R10
  dead_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_top_b_o) || $rose(gate_bot_b_o)) |-> (idle_b >= LIM));

  // R7
  uv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(uv_i, 3) |-> all_off);

  // R5
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_i && !en_ena_i, 3) |-> all_off);

  // R8
  inh_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_i && (inh_a_i || inh_b_i), 3) |-> all_off);

  // R8
  inh_leg_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inh_a_i, 3) |-> (!gate_top_a_o && !gate_bot_a_o));

  // R8
  inh_leg_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inh_b_i, 3) |-> (!gate_top_b_o && !gate_bot_b_o));

endmodule

bind bridge_gate_ctrl bgd_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_i       (mode_i),
  .en_ena_i     (en_ena_i),
  .uv_i         (uv_i),
  .inh_a_i      (inh_a_i),
  .inh_b_i      (inh_b_i),
  .gate_top_a_o (gate_top_a_o),
  .gate_bot_a_o (gate_bot_a_o),
  .gate_top_b_o (gate_top_b_o),
  .gate_bot_b_o (gate_bot_b_o)
);

// File: tb/tb_bridge_gate_ctrl.sv
`timescale 1ns/1ps
module tb_bridge_gate_ctrl;

  localparam int DEAD = 4;
  localparam int NV   = 22;

  // {req id[4], mode dir pwm qs en brk uv inh_a inh_b [9], exp ta ba tb bb [4]}
  localparam logic [16:0] VEC [NV] = '{
    {4'd1,  9'b111110000, 4'b1001},  // R1 dir=1
    {4'd1,  9'b101110000, 4'b0110},  // R1 dir=0
    {4'd2,  9'b110110000, 4'b1000},  // R2
    {4'd2,  9'b100110000, 4'b0010},  // R2
    {4'd3,  9'b111010000, 4'b1001},  // R3 pwm=1
    {4'd3,  9'b110010000, 4'b0000},  // R3 pwm=0
    {4'd3,  9'b100010000, 4'b0000},  // R3 dir=0 pwm=0
    {4'd4,  9'b111111000, 4'b0101},  // R4
    {4'd4,  9'b100011000, 4'b0101},  // R4
    {4'd5,  9'b111101000, 4'b0000},  // R5 brake disabled
    {4'd5,  9'b111100000, 4'b0000},  // R5
    {4'd6,  9'b011010000, 4'b1001},  // R6
    {4'd6,  9'b001110000, 4'b0110},  // R6
    {4'd6,  9'b010110000, 4'b1000},  // R6 leg B disabled
    {4'd6,  9'b011100000, 4'b0010},  // R6 leg A disabled
    {4'd6,  9'b011011000, 4'b1001},  // R6 brake ignored
    {4'd7,  9'b111111100, 4'b0000},  // R7 full + brake
    {4'd7,  9'b011010100, 4'b0000},  // R7 half
    {4'd8,  9'b111110010, 4'b0000},  // R8 full inh_a
    {4'd8,  9'b111111001, 4'b0000},  // R8 full brake inh_b
    {4'd8,  9'b011010010, 4'b0001},  // R8 half inh_a
    {4'd8,  9'b011010001, 4'b1000}   // R8 half inh_b
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_i, dir_ina_i, pwm_enb_i, qs_inb_i, en_ena_i, brk_i, uv_i, inh_a_i, inh_b_i;
  logic gate_top_a_o, gate_bot_a_o, gate_top_b_o, gate_bot_b_o;
  int   checks = 0;
  int   errors = 0;
  logic overlap_seen = 1'b0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  bridge_gate_ctrl #(.DEAD_CYC(DEAD)) dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .dir_ina_i(dir_ina_i),
    .pwm_enb_i(pwm_enb_i), .qs_inb_i(qs_inb_i), .en_ena_i(en_ena_i),
    .brk_i(brk_i), .uv_i(uv_i), .inh_a_i(inh_a_i), .inh_b_i(inh_b_i),
    .gate_top_a_o(gate_top_a_o), .gate_bot_a_o(gate_bot_a_o),
    .gate_top_b_o(gate_top_b_o), .gate_bot_b_o(gate_bot_b_o)
  );

  function automatic logic [3:0] gates();
    return {gate_top_a_o, gate_bot_a_o, gate_top_b_o, gate_bot_b_o};
  endfunction

  // R9 monitor
  always @(negedge clk)
    if (rst_n && ((gate_top_a_o && gate_bot_a_o) || (gate_top_b_o && gate_bot_b_o)))
      overlap_seen = 1'b1;

  task automatic set_in(input logic [8:0] v);
    {mode_i, dir_ina_i, pwm_enb_i, qs_inb_i, en_ena_i, brk_i, uv_i, inh_a_i, inh_b_i} = v;
  endtask

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: gates ta/ba/tb/bb actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic edge_then_sample();
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    set_in(9'b111110000);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 in reset", gates(), 4'b0000);
    rst_n = 1'b1;
    repeat (DEAD) @(negedge clk);
    chk("R12 after release", gates(), 4'b0000);
    repeat (12) @(negedge clk);
    chk("R1 after reset", gates(), 4'b1001);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      set_in(VEC[i][12:4]);
      repeat (14) @(negedge clk);
      chk($sformatf("R%0d vector %0d", VEC[i][16:13], i), gates(), VEC[i][3:0]);
    end

    // R10: side swap timing
    @(negedge clk);
    set_in(9'b111110000);
    repeat (14) @(negedge clk);
    chk("R10 start", gates(), 4'b1001);
    set_in(9'b101110000);
    repeat (2) edge_then_sample();
    chk("R10 before off edge", gates(), 4'b1001);
    edge_then_sample();
    chk("R10 off at edge 3", gates(), 4'b0000);
    repeat (DEAD - 1) edge_then_sample();
    chk("R10 still dead at edge DEAD+2", gates(), 4'b0000);
    edge_then_sample();
    chk("R10 on at edge DEAD+3", gates(), 4'b0110);

    // R11: reverse again mid dead time
    @(negedge clk);
    set_in(9'b111110000);
    repeat (14) @(negedge clk);
    chk("R11 start", gates(), 4'b1001);
    set_in(9'b101110000);
    repeat (4) @(posedge clk);
    @(negedge clk);
    set_in(9'b111110000);
    for (int k = 1; k <= DEAD + 3; k++) begin
      edge_then_sample();
      if (k < DEAD + 3) chk($sformatf("R11 held off edge %0d", k), gates(), 4'b0000);
      else              chk("R11 restart completes", gates(), 4'b1001);
    end

    chk("R9 no overlap seen", {3'b000, overlap_seen}, 4'b0000);

    done = 1'b1;
    summary();
  end

endmodule